// File: doc/BRIEF.md
# Watermark FIFO Drain Controller

This block decides when the 64-bit words held in a capture FIFO are written to system memory. The FIFO reports how many words it holds. A programmable watermark code sets the level at which a drain begins, and a depth-mode input sets the largest code that is legal. The block then drives an abstract memory write port. Each request it raises is either a single-word write or a four-word burst, chosen from the occupancy and from the alignment of the current write address.

The block keeps the write address itself. Software loads a start address, and the block adds 8 bytes for every word the memory side accepts. Once a drain starts, it runs until the FIFO is empty, even after the occupancy has fallen below the watermark. Every accepted word produces one pop strobe toward the FIFO. A new request waits until the memory side has signalled completion of the previous one.

Top module: `wm_drain_ctrl`

## Requirements
- R1: With effective watermark code n, an idle block with an inactive drain raises `wrReq` in the cycle after `fillCount` reaches n*8+1. It raises no request while `fillCount` is below that level.
- R2: After reset the watermark register holds code 2, so the default drain level is 17 words. A pulse on `wmLoad` replaces the code with `wmIn`.
- R3: A code above the mode's maximum is clamped to that maximum. The maximum is 7 when `linearMode`=0 (64-word FIFO, largest level 57) and 23 when `linearMode`=1 (192-word FIFO, largest level 185).
- R4: A request is a burst (`wrBurst`=1, four words) when `fillCount` > 4 and `wrAddr[4:3]`==0 at the decision cycle. Otherwise it is a single word (`wrBurst`=0). `wrBurst` stays constant while `wrReq` is high.
- R5: A word is accepted in each cycle with `wrReq`=1 and `memReady`=1. `popWord` is high in exactly those cycles. A request ends after 4 accepted words for a burst and 1 for a single.
- R6: `wrAddr` advances by 8 on each accepted word. A pulse on `addrLoad` loads `addrIn`.
- R7: After `wrReq` drops, no new request is raised until `memDone` has been seen high.
- R8: Once started, draining continues below the watermark until `fillCount` is 0. The block then re-arms and waits for the watermark again.
- R9: During reset and after it, `wrReq`=0, `popWord`=0 and `wrAddr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fillCount | input | 8 | Words currently held in the FIFO |
| wmLoad | input | 1 | Load strobe for the watermark code |
| wmIn | input | 5 | New watermark code |
| linearMode | input | 1 | 1 = 192-word FIFO (max code 23), 0 = 64-word FIFO (max code 7) |
| addrLoad | input | 1 | Load strobe for the write address |
| addrIn | input | 32 | New write address (bytes) |
| memReady | input | 1 | Memory accepts the offered word this cycle |
| memDone | input | 1 | Memory has finished the previous request |
| wrReq | output | 1 | Write request active |
| wrBurst | output | 1 | 1 = four-word burst, 0 = single word |
| wrAddr | output | 32 | Address of the word being offered |
| popWord | output | 1 | Pop one word from the FIFO |

## Verification
The bench targets the level exactly one word below each watermark. A design with an off-by-one threshold would request there, or would hang one word short. Codes above the mode maximum in both modes expose a missing clamp: the block would then sit idle at the real level. Misaligned start addresses and tails shorter than five words check the burst choice, since a wrong choice shows up as wrong pop counts or wrong addresses. Stalled `memReady` and late `memDone` catch pops that are not tied to acceptance and requests re-issued before completion. Each drain must empty the FIFO fully, and that catches a design that stops at the watermark instead of running to empty.

// File: rtl/wm_drain_pkg.sv
package wm_drain_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_WAIT = 2'd2
  } drainState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;   // latch burst choice, load word counter
    logic accept;  // one word taken by memory
  } drainStrb_t;

endpackage

// File: rtl/wm_drain_dp.sv
module wm_drain_dp
  import wm_drain_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 8,
  parameter int WMW        = 5,
  parameter int WM_RESET   = 2,
  parameter int WM_STEP    = 8,
  parameter int SMALL_MAX  = 7,
  parameter int LARGE_MAX  = 23,
  parameter int BURST_LEN  = 4,
  parameter int WORD_BYTES = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] fillCount,
  input  logic          wmLoad,
  input  logic [WMW-1:0] wmIn,
  input  logic          linearMode,
  input  logic          addrLoad,
  input  logic [AW-1:0] addrIn,
  input  drainStrb_t    strb,
  output logic          thrHit,
  output logic          fifoEmpty,
  output logic          lastWord,
  output logic          burstReg,
  output logic [AW-1:0] wrAddr
);

  localparam int BLW     = $clog2(BURST_LEN);
  localparam int ALIGNLO = $clog2(WORD_BYTES);
  localparam int ALIGNHI = ALIGNLO + BLW - 1;

  logic [WMW-1:0] wmReg;
  logic [WMW-1:0] maxCode;
  logic [WMW-1:0] effCode;
  logic [CW:0]    threshold;
  logic           burstOk;
  logic [BLW-1:0] wordLeft;

  always_ff @(posedge clk) begin
    if (!rstN)       wmReg <= WMW'(WM_RESET);
    else if (wmLoad) wmReg <= wmIn;
  end

  always_comb begin
    maxCode   = linearMode ? WMW'(LARGE_MAX) : WMW'(SMALL_MAX);
    effCode   = (wmReg > maxCode) ? maxCode : wmReg;
    threshold = (CW + 1)'(effCode) * (CW + 1)'(WM_STEP) + (CW + 1)'(1);
    thrHit    = {1'b0, fillCount} >= threshold;
    fifoEmpty = fillCount == '0;
    burstOk   = (fillCount > CW'(BURST_LEN)) && (wrAddr[ALIGNHI:ALIGNLO] == '0);
    lastWord  = wordLeft == '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstReg <= 1'b0;
      wordLeft <= '0;
    end else if (strb.issue) begin
      burstReg <= burstOk;
      wordLeft <= burstOk ? BLW'(BURST_LEN - 1) : '0;
    end else if (strb.accept && !lastWord) begin
      wordLeft <= wordLeft - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            wrAddr <= '0;
    else if (addrLoad)    wrAddr <= addrIn;
    else if (strb.accept) wrAddr <= wrAddr + AW'(WORD_BYTES);
  end

endmodule

// File: rtl/wm_drain_ctl.sv
module wm_drain_ctl
  import wm_drain_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       thrHit,
  input  logic       fifoEmpty,
  input  logic       lastWord,
  input  logic       memReady,
  input  logic       memDone,
  output drainStrb_t strb,
  output logic       wrReq,
  output logic       popWord
);

  drainState_e state, stateNxt;
  logic        drainOn;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    case (state)
      ST_IDLE: if (!fifoEmpty && (thrHit || drainOn)) begin
        strb.issue = 1'b1;
        stateNxt   = ST_XFER;
      end
      ST_XFER: if (memReady) begin
        strb.accept = 1'b1;
        if (lastWord) stateNxt = ST_WAIT;
      end
      ST_WAIT: if (memDone) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      drainOn <= 1'b0;
    end else begin
      state <= stateNxt;
      if (strb.issue)                         drainOn <= 1'b1;
      else if (state == ST_IDLE && fifoEmpty) drainOn <= 1'b0;
    end
  end

  assign wrReq   = state == ST_XFER;
  assign popWord = strb.accept;

endmodule

// File: rtl/wm_drain_ctrl.sv
module wm_drain_ctrl
  import wm_drain_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 8,
  parameter int WMW = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [CW-1:0]  fillCount,
  input  logic           wmLoad,
  input  logic [WMW-1:0] wmIn,
  input  logic           linearMode,
  input  logic           addrLoad,
  input  logic [AW-1:0]  addrIn,
  input  logic           memReady,
  input  logic           memDone,
  output logic           wrReq,
  output logic           wrBurst,
  output logic [AW-1:0]  wrAddr,
  output logic           popWord
);

  drainStrb_t strb;
  logic thrHit, fifoEmpty, lastWord;

  wm_drain_dp #(.AW(AW), .CW(CW), .WMW(WMW)) u_dp (
    .clk(clk), .rstN(rstN), .fillCount(fillCount), .wmLoad(wmLoad),
    .wmIn(wmIn), .linearMode(linearMode), .addrLoad(addrLoad),
    .addrIn(addrIn), .strb(strb), .thrHit(thrHit), .fifoEmpty(fifoEmpty),
    .lastWord(lastWord), .burstReg(wrBurst), .wrAddr(wrAddr)
  );

  wm_drain_ctl u_ctl (
    .clk(clk), .rstN(rstN), .thrHit(thrHit), .fifoEmpty(fifoEmpty),
    .lastWord(lastWord), .memReady(memReady), .memDone(memDone),
    .strb(strb), .wrReq(wrReq), .popWord(popWord)
  );

endmodule

// File: rtl/wm_drain_ctrl_chk.sv
module wm_drain_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrReq,
  input logic          wrBurst,
  input logic [AW-1:0] wrAddr,
  input logic          popWord,
  input logic          memReady,
  input logic          memDone,
  input logic          addrLoad
);

  logic       reqD;
  logic       donePending;
  logic [2:0] popsSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqD        <= 1'b0;
      donePending <= 1'b0;
      popsSeen    <= '0;
    end else begin
      reqD <= wrReq;
      if (reqD && !wrReq && !memDone) donePending <= 1'b1;
      else if (memDone)               donePending <= 1'b0;
      if (!wrReq)       popsSeen <= '0;
      else if (popWord) popsSeen <= popsSeen + 1'b1;
    end
  end

  a_r5_pop_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    popWord |-> (wrReq && memReady));

  a_r5_words_per_req: assert property (@(posedge clk) disable iff (!rstN)
    (reqD && !wrReq) |-> (popsSeen == ($past(wrBurst) ? 3'd4 : 3'd1)));

  a_r4_burst_stable: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && reqD) |-> $stable(wrBurst));

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (popWord && !addrLoad) |=> (wrAddr == $past(wrAddr) + AW'(8)));

  a_r7_wait_done: assert property (@(posedge clk) disable iff (!rstN)
    donePending |-> !wrReq);

endmodule

bind wm_drain_ctrl wm_drain_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .wrReq(wrReq), .wrBurst(wrBurst), .wrAddr(wrAddr),
  .popWord(popWord), .memReady(memReady), .memDone(memDone), .addrLoad(addrLoad)
);

// File: tb/wm_drain_ctrl_tb.sv
module wm_drain_ctrl_tb;

  localparam time CLK_P = 8ns;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  fillCount;
  logic        wmLoad;
  logic [4:0]  wmIn;
  logic        linearMode;
  logic        addrLoad;
  logic [31:0] addrIn;
  logic        memReady;
  logic        memDone;
  logic        wrReq, wrBurst, popWord;
  logic [31:0] wrAddr;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P / 2) clk = ~clk;

  wm_drain_ctrl u_dut (
    .clk(clk), .rstN(rstN), .fillCount(fillCount), .wmLoad(wmLoad), .wmIn(wmIn),
    .linearMode(linearMode), .addrLoad(addrLoad), .addrIn(addrIn),
    .memReady(memReady), .memDone(memDone), .wrReq(wrReq), .wrBurst(wrBurst),
    .wrAddr(wrAddr), .popWord(popWord)
  );

  typedef struct packed {
    logic [4:0]  code;
    logic        lin;
    logic [15:0] addr;
    logic [7:0]  thr;
    logic        burst;
    logic        stall;
    logic [2:0]  dly;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{5'd0,  1'b0, 16'h0000, 8'd1,   1'b0, 1'b0, 3'd0},
    '{5'd1,  1'b0, 16'h0100, 8'd9,   1'b1, 1'b0, 3'd2},
    '{5'd7,  1'b0, 16'h0008, 8'd57,  1'b0, 1'b1, 3'd1},
    '{5'd9,  1'b0, 16'h0020, 8'd57,  1'b1, 1'b0, 3'd0},
    '{5'd23, 1'b1, 16'h0018, 8'd185, 1'b0, 1'b1, 3'd3},
    '{5'd31, 1'b1, 16'h0040, 8'd185, 1'b1, 1'b0, 3'd0},
    '{5'd12, 1'b1, 16'h0000, 8'd97,  1'b1, 1'b1, 3'd4},
    '{5'd23, 1'b0, 16'h0000, 8'd57,  1'b1, 1'b0, 3'd2}
  };

  // results of one drain run
  int          fill;
  logic [31:0] addrModel;
  int          pops, burstErr, cntErr, addrErr, waitErr;
  logic        firstBurst;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // memory and FIFO model; runs until the FIFO is empty and the block idles
  task automatic drain(input logic stall, input int dly);
    logic prevReq  = 1'b0;
    logic curBurst = 1'b0;
    logic first    = 1'b1;
    int   curPops  = 0;
    int   doneWait = -1;
    int   idle     = 0;
    pops = 0; burstErr = 0; cntErr = 0; addrErr = 0; waitErr = 0;
    firstBurst = 1'b0;
    for (int cyc = 0; cyc < 5000 && idle < 6; cyc++) begin
      @(negedge clk);
      fillCount = 8'(fill);
      memDone   = 1'b0;
      if (wrReq && !prevReq) begin
        if (first) firstBurst = wrBurst;
        first = 1'b0;
        if (wrBurst !== ((fill > 4) && (addrModel[4:3] == 2'b00))) burstErr++;
        curBurst = wrBurst;
        curPops  = 0;
      end
      if (!wrReq && prevReq) begin
        if (curPops != (curBurst ? 4 : 1)) cntErr++;
        doneWait = dly;
      end
      if (doneWait >= 0) begin
        if (wrReq) waitErr++;
        if (doneWait == 0) memDone = 1'b1;
        doneWait--;
      end
      memReady = wrReq && !(stall && cyc[0]);
      prevReq  = wrReq;
      #1;
      if (popWord) begin
        if (wrAddr !== addrModel) addrErr++;
        addrModel += 32'd8;
        pops++;
        curPops++;
        fill--;
      end
      if (fill == 0 && !wrReq && doneWait < 0) idle++;
      else idle = 0;
    end
    @(negedge clk);
    fillCount = 8'(fill);
    memReady  = 1'b0;
    memDone   = 1'b0;
  endtask

  task automatic noReqFor(input int n, input string tag);
    logic seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (wrReq) seen = 1'b1;
    end
    check(tag, seen, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; fillCount = '0; wmLoad = 0; wmIn = '0; linearMode = 0;
    addrLoad = 0; addrIn = '0; memReady = 0; memDone = 0;
    repeat (3) @(negedge clk);
    check("R9 reset wrReq", wrReq, 0);
    check("R9 reset popWord", popWord, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 reset wrAddr", wrAddr, 0);

    // R2 default watermark code 2 -> 17 words
    fill = 16; fillCount = 8'd16; addrModel = 32'd0;
    noReqFor(6, "R2 default level below 17");
    fill = 17;
    drain(1'b0, 1);
    check("R2 default drain words", pops, 17);
    check("R8 default drain empties", fill, 0);
    check("R4 default first burst", firstBurst, 1);

    // table walk: R1 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      vec_t v = VEC[i];
      @(negedge clk);
      fill = 0; fillCount = '0;
      wmLoad = 1; wmIn = v.code; linearMode = v.lin;
      addrLoad = 1; addrIn = {16'h0, v.addr};
      @(negedge clk);
      wmLoad = 0; addrLoad = 0;
      addrModel = {16'h0, v.addr};
      fill = int'(v.thr) - 1; fillCount = 8'(fill);
      noReqFor(6, $sformatf("R1 R3 vec%0d idle one below level", i));
      fill = int'(v.thr);
      drain(v.stall, int'(v.dly));
      check($sformatf("R1 R3 R8 vec%0d words drained", i), pops, v.thr);
      check($sformatf("R8 vec%0d fifo emptied", i), fill, 0);
      check($sformatf("R4 vec%0d first burst", i), firstBurst, v.burst);
      check($sformatf("R4 vec%0d burst choices", i), burstErr, 0);
      check($sformatf("R5 vec%0d words per request", i), cntErr, 0);
      check($sformatf("R6 vec%0d per-word address", i), addrErr, 0);
      check($sformatf("R6 vec%0d final address", i), wrAddr, {16'h0, v.addr} + 32'(v.thr) * 8);
      check($sformatf("R7 vec%0d no request before done", i), waitErr, 0);
    end

    // R8 re-arm: after draining to empty, a small count below the level stays put
    @(negedge clk);
    wmLoad = 1; wmIn = 5'd3; linearMode = 0;
    @(negedge clk);
    wmLoad = 0;
    fill = 3; fillCount = 8'd3;
    noReqFor(8, "R8 rearmed idle at 3 words");
    check("R5 no pop while idle", popWord, 0);
    fill = 25;
    drain(1'b0, 0);
    check("R1 level 25 drained", pops, 25);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule